// File: doc/BRIEF.md
# Tap-Changer Voltage Regulation Controller

This block picks the turns-ratio tap of an electronic tap-changer so that the measured amplitude of the regulated bus follows a voltage setpoint. It works on amplitudes that an upstream detector has already measured. Each time a measurement strobe arrives, it forms a feed-forward ratio estimate. The estimate is the primary amplitude times a programmed reciprocal of the setpoint. The block adds an integral correction to this estimate. The correction is driven by the bus error after a deadband, and the deadband keeps the residual error from tap quantization out of the loop.

The summed ratio command is rounded to the nearest legal tap index between a programmable minimum ratio and a programmable top index. The switch stage may only change taps at a load-current zero crossing. For this reason the rounded index is held in a sample-and-hold register that loads only on a zero-crossing strobe. A one-cycle pulse marks every change of the held index. The integral term saturates so that the command never leaves the tap range, which stops wind-up while the tap sits at a limit.

Ratios are unsigned fixed point with `RF` fractional bits (4096 means 1.0 at the default). The reciprocal input has `RCW` bits, all of them fractional.

Top module: `tap_reg_ctrl`

## Requirements
- R1: While reset is high and on the first cycle after it, `tap_idx` equals `NOM_TAP` (default 4) and `tap_upd` is 0. The integral term is cleared.
- R2: The ratio command is the feed-forward bias `(v1_amp * vref_recip) >> (RCW - RF)` plus the integral term. The bias is sampled on each measurement strobe.
- R3: On each cycle with `meas_vld` high, the integral term becomes `integ - ((e_dz * cfg_ki) >>> KI_SHIFT)`. Here `e_dz` is the deadbanded value of `vref - vbus_amp`. Without a strobe the integral term does not change.
- R4: Deadband: when `|vref - vbus_amp| <= cfg_db` the error passed to the integrator is 0. Otherwise the raw signed error is passed.
- R5: After each update, the integral term is clamped so that bias plus integral lies within `[cfg_tap_min, cfg_tap_min + top*cfg_tap_step]`. Leaving a limit therefore takes only as many strobes as the in-range distance requires.
- R6: The command is quantized to the nearest index `k` in `0..top`, where tap `k` has the ratio `cfg_tap_min + k*cfg_tap_step`. A command exactly halfway between two taps rounds to the higher index.
- R7: `tap_idx` loads the quantized index only on a cycle with `zc_strobe` high. At all other times it holds its value.
- R8: `tap_upd` is high for exactly the one cycle after a zero-crossing load that changed `tap_idx`. A load that leaves the index unchanged gives no pulse.
- R9: After reset, zero-crossing strobes are ignored until the first measurement strobe has been taken.
- R10: The top index `cfg_tap_top` (capped at `NTAP-1`) limits both the quantizer and the saturation range.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| meas_vld | input | 1 | Measurement strobe, one cycle per new amplitude set |
| v1_amp | input | VW | Primary voltage amplitude |
| vbus_amp | input | VW | Regulated-bus voltage amplitude |
| vref | input | VW | Bus amplitude setpoint |
| vref_recip | input | RCW | Reciprocal of the setpoint, all fractional bits |
| zc_strobe | input | 1 | Load-current zero-crossing strobe |
| cfg_ki | input | KW | Integrator gain |
| cfg_db | input | VW | Deadband half-width in amplitude units |
| cfg_tap_min | input | RW | Ratio of tap 0 |
| cfg_tap_step | input | RW | Ratio increment per tap |
| cfg_tap_top | input | IDXW | Highest legal tap index |
| tap_idx | output | IDXW | Held tap index |
| tap_upd | output | 1 | One-cycle pulse when `tap_idx` changed |

## Verification
A corrupted integral term or feed-forward register stays invisible at the ports until the next zero-crossing strobe after it. It then appears as a wrong `tap_idx` together with a wrong or missing `tap_upd` pulse. The deadband and the clamp can hide small errors, so the tests drive the error across the deadband edge by exactly one unit. They also count strobes to the precise step at which the index must move. Leaving a limit is timed as well: an accumulator that winds up shows as a tap that stays stuck for many extra strobes.

// File: rtl/tap_reg_pkg.sv
package tap_reg_pkg;
  localparam int VW_DEF       = 12;  // amplitude width
  localparam int RW_DEF       = 16;  // ratio width
  localparam int RF_DEF       = 12;  // ratio fractional bits
  localparam int RCW_DEF      = 16;  // reciprocal width, all fractional
  localparam int KW_DEF       = 8;   // gain width
  localparam int KI_SHIFT_DEF = 4;   // gain scaling shift
  localparam int NTAP_DEF     = 16;  // number of physical taps
  localparam int NOM_TAP_DEF  = 4;   // tap selected at reset
  localparam int CW_DEF       = 28;  // signed internal ratio width
endpackage

// File: rtl/tap_ff_bias.sv
module tap_ff_bias #(
  parameter int VW  = 12,
  parameter int RCW = 16,
  parameter int RF  = 12,
  parameter int CW  = 28
) (
  input  logic [VW-1:0]        v1_amp,
  input  logic [RCW-1:0]       vref_recip,
  output logic signed [CW-1:0] bias
);
  localparam int PW = VW + RCW;
  localparam int SH = RCW - RF;

  logic [PW-1:0] prod;
  logic [PW-1:0] scaled;

  always_comb begin
    prod   = PW'(v1_amp) * PW'(vref_recip);
    scaled = prod >> SH;
    bias   = $signed(CW'(scaled));
  end
endmodule

// File: rtl/tap_integrator.sv
module tap_integrator #(
  parameter int VW       = 12,
  parameter int KW       = 8,
  parameter int KI_SHIFT = 4,
  parameter int CW       = 28
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 step_en,
  input  logic [VW-1:0]        vref,
  input  logic [VW-1:0]        vbus_amp,
  input  logic [VW-1:0]        cfg_db,
  input  logic [KW-1:0]        cfg_ki,
  input  logic signed [CW-1:0] bias,
  input  logic signed [CW-1:0] lo_lim,
  input  logic signed [CW-1:0] hi_lim,
  output logic signed [CW-1:0] integ_q
);
  localparam int EW = VW + 1;
  localparam int PW = EW + KW + 1;

  logic signed [EW-1:0] err_s, err_mag, err_dz, db_s;
  logic signed [PW-1:0] err_x, ki_x, prod;
  logic signed [CW-1:0] prod_ext, delta, sum, lo, hi, nxt;

  always_comb begin
    err_s   = $signed({1'b0, vref}) - $signed({1'b0, vbus_amp});
    err_mag = err_s[EW-1] ? -err_s : err_s;
    db_s    = $signed({1'b0, cfg_db});
    err_dz  = (err_mag <= db_s) ? '0 : err_s;
    err_x   = {{(PW-EW){err_dz[EW-1]}}, err_dz};
    ki_x    = $signed({{(PW-KW){1'b0}}, cfg_ki});
    prod    = err_x * ki_x;
    prod_ext = {{(CW-PW){prod[PW-1]}}, prod};
    delta   = prod_ext >>> KI_SHIFT;
    sum     = integ_q - delta;
    lo      = lo_lim - bias;
    hi      = hi_lim - bias;
    if (sum < lo)      nxt = lo;
    else if (sum > hi) nxt = hi;
    else               nxt = sum;
  end

  always_ff @(posedge clk) begin
    if (rst)          integ_q <= '0;
    else if (step_en) integ_q <= nxt;
  end
endmodule

// File: rtl/tap_quantizer.sv
module tap_quantizer #(
  parameter int NTAP = 16,
  parameter int RW   = 16,
  parameter int CW   = 28,
  parameter int IDXW = $clog2(NTAP)
) (
  input  logic signed [CW-1:0] cmd,
  input  logic [RW-1:0]        tap_min,
  input  logic [RW-1:0]        tap_step,
  input  logic [IDXW-1:0]      top,
  output logic [IDXW-1:0]      idx
);
  logic [NTAP-1:1] hit;
  logic signed [CW-1:0] base_s, step_s, half_s;

  always_comb begin
    base_s = $signed(CW'(tap_min));
    step_s = $signed(CW'(tap_step));
    half_s = $signed(CW'(tap_step >> 1));
  end

  for (genvar k = 1; k < NTAP; k++) begin : g_thr
    logic signed [CW-1:0] thr;
    assign thr    = base_s + $signed(CW'(k)) * step_s - half_s;
    assign hit[k] = (IDXW'(k) <= top) && (cmd >= thr);
  end

  always_comb begin
    idx = '0;
    for (int k = 1; k < NTAP; k++) idx = idx + IDXW'(hit[k]);
  end
endmodule

// File: rtl/tap_reg_ctrl.sv
module tap_reg_ctrl
  import tap_reg_pkg::*;
#(
  parameter int VW       = VW_DEF,
  parameter int RW       = RW_DEF,
  parameter int RF       = RF_DEF,
  parameter int RCW      = RCW_DEF,
  parameter int KW       = KW_DEF,
  parameter int KI_SHIFT = KI_SHIFT_DEF,
  parameter int NTAP     = NTAP_DEF,
  parameter int NOM_TAP  = NOM_TAP_DEF,
  parameter int CW       = CW_DEF,
  localparam int IDXW    = $clog2(NTAP)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            meas_vld,
  input  logic [VW-1:0]   v1_amp,
  input  logic [VW-1:0]   vbus_amp,
  input  logic [VW-1:0]   vref,
  input  logic [RCW-1:0]  vref_recip,
  input  logic            zc_strobe,
  input  logic [KW-1:0]   cfg_ki,
  input  logic [VW-1:0]   cfg_db,
  input  logic [RW-1:0]   cfg_tap_min,
  input  logic [RW-1:0]   cfg_tap_step,
  input  logic [IDXW-1:0] cfg_tap_top,
  output logic [IDXW-1:0] tap_idx,
  output logic            tap_upd
);
  localparam logic [IDXW-1:0] TOP_MAX = IDXW'(NTAP - 1);

  logic [IDXW-1:0]      top_eff, idx_next;
  logic signed [CW-1:0] bias, ff_q, integ_q, cmd, lo_lim, hi_lim;
  logic                 primed_q;

  always_comb begin
    top_eff = (cfg_tap_top > TOP_MAX) ? TOP_MAX : cfg_tap_top;
    lo_lim  = $signed(CW'(cfg_tap_min));
    hi_lim  = lo_lim + $signed(CW'(top_eff)) * $signed(CW'(cfg_tap_step));
    cmd     = ff_q + integ_q;
  end

  tap_ff_bias #(.VW(VW), .RCW(RCW), .RF(RF), .CW(CW)) u_ff (
    .v1_amp(v1_amp), .vref_recip(vref_recip), .bias(bias)
  );

  tap_integrator #(.VW(VW), .KW(KW), .KI_SHIFT(KI_SHIFT), .CW(CW)) u_int (
    .clk(clk), .rst(rst), .step_en(meas_vld), .vref(vref),
    .vbus_amp(vbus_amp), .cfg_db(cfg_db), .cfg_ki(cfg_ki), .bias(bias),
    .lo_lim(lo_lim), .hi_lim(hi_lim), .integ_q(integ_q)
  );

  tap_quantizer #(.NTAP(NTAP), .RW(RW), .CW(CW)) u_q (
    .cmd(cmd), .tap_min(cfg_tap_min), .tap_step(cfg_tap_step),
    .top(top_eff), .idx(idx_next)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ff_q     <= '0;
      primed_q <= 1'b0;
      tap_idx  <= IDXW'(NOM_TAP);
      tap_upd  <= 1'b0;
    end else begin
      tap_upd <= 1'b0;
      if (meas_vld) begin
        ff_q     <= bias;
        primed_q <= 1'b1;
      end
      if (zc_strobe && primed_q) begin
        tap_idx <= idx_next;
        tap_upd <= (idx_next != tap_idx);
      end
    end
  end
endmodule

// File: rtl/tap_reg_chk.sv
module tap_reg_chk #(
  parameter int CW      = 28,
  parameter int IDXW    = 4,
  parameter int NOM_TAP = 4
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 meas_vld,
  input logic                 zc_strobe,
  input logic                 primed,
  input logic [IDXW-1:0]      tap_idx,
  input logic                 tap_upd,
  input logic signed [CW-1:0] integ
);
  AST_RESET_NOMINAL: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (tap_idx == IDXW'(NOM_TAP) && !tap_upd)); // R1
  AST_INTEG_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(meas_vld)) |-> $stable(integ)); // R3
  AST_TAP_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(zc_strobe)) |-> $stable(tap_idx)); // R7
  AST_UPD_FROM_ZC: assert property (@(posedge clk) disable iff (rst)
    tap_upd |-> $past(zc_strobe)); // R8
  AST_UPD_CHANGED: assert property (@(posedge clk) disable iff (rst)
    tap_upd |-> (tap_idx != $past(tap_idx))); // R8
  AST_UNPRIMED_NOM: assert property (@(posedge clk) disable iff (rst)
    !primed |-> (tap_idx == IDXW'(NOM_TAP))); // R9
endmodule

bind tap_reg_ctrl tap_reg_chk #(.CW(CW), .IDXW(IDXW), .NOM_TAP(NOM_TAP)) u_chk (
  .clk(clk), .rst(rst), .meas_vld(meas_vld), .zc_strobe(zc_strobe),
  .primed(primed_q), .tap_idx(tap_idx), .tap_upd(tap_upd), .integ(integ_q)
);

// File: tb/tap_reg_ctrl_bench.sv
module tap_reg_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        meas_vld = 1'b0, zc_strobe = 1'b0;
  logic [11:0] v1_amp = 12'd1024, vbus_amp = 12'd1024, vref = 12'd1024;
  logic [15:0] vref_recip = 16'd64;
  logic [7:0]  cfg_ki = 8'd0;
  logic [11:0] cfg_db = 12'd0;
  logic [15:0] cfg_tap_min = 16'd3584, cfg_tap_step = 16'd256;
  logic [3:0]  cfg_tap_top = 4'd7;
  logic [3:0]  tap_idx;
  logic        tap_upd;
  int errors = 0, checks = 0;
  bit done = 0;

  always #5 clk = ~clk;

  tap_reg_ctrl u_tap_reg_ctrl (
    .clk(clk), .rst(rst), .meas_vld(meas_vld), .v1_amp(v1_amp),
    .vbus_amp(vbus_amp), .vref(vref), .vref_recip(vref_recip),
    .zc_strobe(zc_strobe), .cfg_ki(cfg_ki), .cfg_db(cfg_db),
    .cfg_tap_min(cfg_tap_min), .cfg_tap_step(cfg_tap_step),
    .cfg_tap_top(cfg_tap_top), .tap_idx(tap_idx), .tap_upd(tap_upd)
  );

  // {v1_amp, expected tap}, ki = 0: bias = 4*v1, tap k at 3584 + 256*k
  localparam logic [15:0] VECS [0:7] = '{
    {12'd1024, 4'd2}, {12'd896, 4'd0}, {12'd800, 4'd0}, {12'd1400, 4'd7},
    {12'd1056, 4'd3}, {12'd1055, 4'd2}, {12'd1120, 4'd4}, {12'd960, 4'd1}
  };

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk) rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic meas(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) meas_vld = 1'b1;
      @(negedge clk) meas_vld = 1'b0;
    end
  endtask

  task automatic zc_check(string req, int exp_idx, int exp_upd);
    @(negedge clk) zc_strobe = 1'b1;
    @(negedge clk) zc_strobe = 1'b0;
    chk(req, tap_idx, exp_idx);
    chk(req, tap_upd, exp_upd);
    @(negedge clk);
    chk(req, tap_upd, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R2 R6: feed-forward and rounding table
    for (int i = 0; i < 8; i++) begin
      do_reset();
      v1_amp = VECS[i][15:4];
      meas(1);
      zc_check("R2/R6", int'(VECS[i][3:0]), (VECS[i][3:0] != 4'd4) ? 1 : 0);
    end

    // R1 R9: reset state, strobe ignored before first measurement
    cfg_ki = 8'd16; cfg_db = 12'd10; v1_amp = 12'd1024; vbus_amp = 12'd1020;
    do_reset();
    chk("R1", tap_idx, 4);
    chk("R1", tap_upd, 0);
    zc_check("R9", 4, 0);
    meas(1);
    zc_check("R8", 2, 1);
    zc_check("R8", 2, 0);

    // R3: no strobe, no change even with new inputs
    v1_amp = 12'd1400; vbus_amp = 12'd0;
    repeat (10) @(negedge clk);
    zc_check("R3", 2, 0);
    v1_amp = 12'd1024;

    // R4: error equal to deadband is ignored
    vbus_amp = 12'd1014;
    meas(20);
    zc_check("R4", 2, 0);
    // R3: error 24 per strobe, 6 strobes needed to reach tap 1
    vbus_amp = 12'd1000;
    meas(5);
    zc_check("R3", 2, 0);
    meas(1);
    @(negedge clk);
    chk("R7", tap_idx, 2);
    zc_check("R3", 1, 1);

    // R4: negative side of the deadband
    do_reset();
    vbus_amp = 12'd1034;
    meas(20);
    zc_check("R4", 2, 1);
    vbus_amp = 12'd1035;
    meas(11);
    zc_check("R4", 2, 0);
    meas(1);
    zc_check("R6", 3, 1);

    // R5: anti-windup at lower and upper limit
    do_reset();
    vbus_amp = 12'd0;
    meas(10);
    zc_check("R5", 0, 1);
    vbus_amp = 12'd1088;
    meas(4);
    zc_check("R5", 1, 1);
    vbus_amp = 12'd2048;
    meas(5);
    zc_check("R5", 7, 1);
    vbus_amp = 12'd960;
    meas(4);
    zc_check("R5", 6, 1);

    // R10: reduced top index
    do_reset();
    cfg_ki = 8'd0; cfg_tap_top = 4'd3; v1_amp = 12'd1400; vbus_amp = 12'd1024;
    meas(1);
    zc_check("R10", 3, 1);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule